// File: doc/BRIEF.md
# Reconfigurable Column-Wise CAM Array

This block models a 64-row by 64-column bit array that can serve as a binary content-addressable memory, as a ternary content-addressable memory, or as an ordinary row-addressed SRAM. In the two CAM modes each stored word runs down a column. The search key is applied across the rows in true and complement form. Every column then reports two flags, each of which says whether one of its two precharged lines stayed high. These flags are combined into a per-word match vector, which is registered.

Binary mode gives one 64-bit word per column, so 64 words can be searched at once. Ternary mode pairs columns 2w and 2w+1 into word w, which gives 32 words with per-bit don't-care. SRAM mode reads and writes whole rows by row address. An external sequencer loads words through a separate column-write port, one whole column per cycle. The operating mode may only change while the array is idle, and changing it leaves the stored bits as they are.

Top module: `cfgcam_top`

## Requirements
- R1: While rst_n is low at a clock edge, match_vec and sram_rdata are cleared and the mode becomes binary CAM (mode code 0); the other codes are ternary 1, SRAM 2, and code 3 is never adopted.
- R2: In binary mode, after a search, match_vec bit c is 1 exactly when column c holds the key (row m of the column equals key bit m).
- R3: In binary mode, a key that differs from a stored column in any single row clears that column's match bit, for a differing 1 as well as a differing 0.
- R4: In ternary mode, word w uses column 2w (A) and column 2w+1 (B); per row, value 1 is A=1,B=1, value 0 is A=0,B=0, and don't-care is A=1,B=0. After a search, bits 63..32 of match_vec are 0.
- R5: A ternary row holding don't-care matches key bit 0 and key bit 1; word w matches only when every row matches.
- R6: match_vec takes a new value only on the clock edge after a cycle with srch_go high in a CAM mode; otherwise it holds.
- R7: In SRAM mode, a write stores sram_wdata bit c into column c of the addressed row, and a read returns that row on sram_rdata from the following edge. sram_rdata holds at all other times.
- R8: The SRAM port does nothing in CAM modes, the column-write port does nothing in SRAM mode, and srch_go does nothing in SRAM mode.
- R9: A mode load is taken only in a cycle where srch_go, colw_en and sram_en are all low. Array contents survive every mode change.
- R10: A column written through the column port shows up as bit c of every row when the array is read in SRAM mode, so column and row views address the same cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Requested mode code |
| mode_ld | input | 1 | Load mode_sel into the mode register |
| mode_cur | output | 2 | Current mode code |
| srch_go | input | 1 | Search strobe |
| srch_key | input | 64 | Search key, bit m drives row m |
| match_vec | output | 64 | Registered per-word match flags |
| colw_en | input | 1 | Column write strobe |
| colw_idx | input | 6 | Column to write |
| colw_data | input | 64 | Column contents, bit m for row m |
| sram_en | input | 1 | SRAM access strobe |
| sram_we | input | 1 | 1 = write row, 0 = read row |
| sram_row | input | 6 | SRAM row address |
| sram_wdata | input | 64 | Row write data, bit c for column c |
| sram_rdata | output | 64 | Registered row read data |

## Verification
On every cycle the assertions check the following: match_vec and sram_rdata hold unless a search or read actually started, the mode does not move while the array is busy, the upper half of the match vector is zero after a ternary search, and reset brings the block back to binary mode. Whether a given column matches a given key, including single-row mismatches, multiple matching columns, don't-care rows, survival of contents across mode switches, and agreement between the column and row views, can only be shown by the bench's scenarios. Those scenarios compare the outputs against words the bench itself stored.

// File: rtl/cfgcam_pkg.sv
// Shared types for the reconfigurable CAM array.
// Assumes a 2-bit mode code; code 3 is reserved and never adopted.
package cfgcam_pkg;
    typedef enum logic [1:0] {
        MODE_BCAM = 2'd0,
        MODE_TCAM = 2'd1,
        MODE_SRAM = 2'd2
    } cam_mode_e;
endpackage

// File: rtl/cfgcam_cell_array.sv
// Bit storage for the array: cells[m][c] is row m, column c.
// Offers a whole-column write, a whole-row write and a combinational
// row read. Assumes the caller never enables both writes in one cycle.
module cfgcam_cell_array #(
    parameter int ROWS = 64,
    parameter int COLS = 64,
    localparam int RIW = $clog2(ROWS),
    localparam int CIW = $clog2(COLS)
) (
    input  logic                      clk,
    input  logic                      col_we,
    input  logic [CIW-1:0]            col_idx,
    input  logic [ROWS-1:0]           col_data,
    input  logic                      row_we,
    input  logic [RIW-1:0]            row_idx,
    input  logic [COLS-1:0]           row_wdata,
    output logic [ROWS-1:0][COLS-1:0] cells,
    output logic [COLS-1:0]           row_rdata
);
    // Update storage from the column port or the row port.
    always_ff @(posedge clk) begin
        if (col_we) begin
            for (int m = 0; m < ROWS; m++) begin
                cells[m][col_idx] <= col_data[m];
            end
        end else if (row_we) begin
            cells[row_idx] <= row_wdata;
        end
    end

    // Present the addressed row for the SRAM read path.
    always_comb row_rdata = cells[row_idx];
endmodule

// File: rtl/cfgcam_col_sense.sv
// Column line evaluation for a search. For each column, line_t stays high
// unless a row with key bit 1 stores 0; line_f stays high unless a row
// with key bit 0 stores 1. Models two precharged single-ended lines.
module cfgcam_col_sense #(
    parameter int ROWS = 64,
    parameter int COLS = 64
) (
    input  logic [ROWS-1:0][COLS-1:0] cells,
    input  logic [ROWS-1:0]           key,
    output logic [COLS-1:0]           line_t,
    output logic [COLS-1:0]           line_f
);
    for (genvar c = 0; c < COLS; c++) begin : g_col
        // Discharge each line on any pulling row in this column.
        always_comb begin
            line_t[c] = 1'b1;
            line_f[c] = 1'b1;
            for (int m = 0; m < ROWS; m++) begin
                if (key[m] && !cells[m][c]) line_t[c] = 1'b0;
                if (!key[m] && cells[m][c]) line_f[c] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/cfgcam_match_comb.sv
// Combines sensed column lines into per-word match flags.
// Binary: word c = line_t[c] & line_f[c]. Ternary: word w =
// line_t[2w] & line_f[2w+1], upper half forced to 0. SRAM: all 0.
// Assumes COLS is even.
module cfgcam_match_comb #(
    parameter int COLS = 64
) (
    input  cfgcam_pkg::cam_mode_e mode,
    input  logic [COLS-1:0]       line_t,
    input  logic [COLS-1:0]       line_f,
    output logic [COLS-1:0]       match
);
    import cfgcam_pkg::*;
    localparam int TWORDS = COLS / 2;

    for (genvar w = 0; w < COLS; w++) begin : g_word
        if (w < TWORDS) begin : g_low
            // Lower words exist in both CAM modes.
            always_comb begin
                unique case (mode)
                    MODE_BCAM: match[w] = line_t[w] & line_f[w];
                    MODE_TCAM: match[w] = line_t[2*w] & line_f[2*w+1];
                    default:   match[w] = 1'b0;
                endcase
            end
        end else begin : g_high
            // Upper words exist only in binary mode.
            always_comb match[w] = (mode == MODE_BCAM) & line_t[w] & line_f[w];
        end
    end
endmodule

// File: rtl/cfgcam_top.sv
// Reconfigurable column-wise CAM / TCAM / SRAM array.
// Holds the mode register, gates each port by mode, registers the match
// vector and the SRAM read data. Assumes writes are sequenced externally.
module cfgcam_top #(
    parameter int ROWS = 64,
    parameter int COLS = 64,
    localparam int RIW = $clog2(ROWS),
    localparam int CIW = $clog2(COLS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode_sel,
    input  logic            mode_ld,
    output logic [1:0]      mode_cur,
    input  logic            srch_go,
    input  logic [ROWS-1:0] srch_key,
    output logic [COLS-1:0] match_vec,
    input  logic            colw_en,
    input  logic [CIW-1:0]  colw_idx,
    input  logic [ROWS-1:0] colw_data,
    input  logic            sram_en,
    input  logic            sram_we,
    input  logic [RIW-1:0]  sram_row,
    input  logic [COLS-1:0] sram_wdata,
    output logic [COLS-1:0] sram_rdata
);
    import cfgcam_pkg::*;

    cam_mode_e                mode_q;
    logic                     busy, is_cam, col_we, row_we, row_rd;
    logic [ROWS-1:0][COLS-1:0] cells;
    logic [COLS-1:0]          row_rdata, line_t, line_f, match_d;

    // Decode port activity against the current mode.
    always_comb begin
        busy   = srch_go | colw_en | sram_en;
        is_cam = (mode_q != MODE_SRAM);
        col_we = colw_en & is_cam;
        row_we = sram_en & sram_we & ~is_cam;
        row_rd = sram_en & ~sram_we & ~is_cam;
    end

    // Mode register: loads only while idle and only valid codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_BCAM;
        end else if (mode_ld && !busy && mode_sel != 2'd3) begin
            mode_q <= cam_mode_e'(mode_sel);
        end
    end

    assign mode_cur = mode_q;

    cfgcam_cell_array #(.ROWS(ROWS), .COLS(COLS)) u_array (
        .clk      (clk),
        .col_we   (col_we),
        .col_idx  (colw_idx),
        .col_data (colw_data),
        .row_we   (row_we),
        .row_idx  (sram_row),
        .row_wdata(sram_wdata),
        .cells    (cells),
        .row_rdata(row_rdata)
    );

    cfgcam_col_sense #(.ROWS(ROWS), .COLS(COLS)) u_sense (
        .cells (cells),
        .key   (srch_key),
        .line_t(line_t),
        .line_f(line_f)
    );

    cfgcam_match_comb #(.COLS(COLS)) u_comb (
        .mode  (mode_q),
        .line_t(line_t),
        .line_f(line_f),
        .match (match_d)
    );

    // Capture the match vector on a search in a CAM mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_vec <= '0;
        end else if (srch_go && is_cam) begin
            match_vec <= match_d;
        end
    end

    // Capture the addressed row on an SRAM read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_rdata <= '0;
        end else if (row_rd) begin
            sram_rdata <= row_rdata;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (match_vec == '0 && sram_rdata == '0 && mode_q == MODE_BCAM));

    // R6
    match_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(srch_go && mode_q != MODE_SRAM) |=> $stable(match_vec));

    // R4
    tcam_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_go && mode_q == MODE_TCAM) |=> (match_vec[COLS-1:COLS/2] == '0));

    // R9
    mode_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_go || colw_en || sram_en) |=> $stable(mode_q));

    // R7
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sram_en && !sram_we && mode_q == MODE_SRAM) |=> $stable(sram_rdata));
endmodule

// File: tb/cfgcam_top_test.sv
`timescale 1ns/1ps
module cfgcam_top_test;
    localparam int ROWS = 64;
    localparam int COLS = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      mode_sel = 2'd0;
    logic            mode_ld = 1'b0;
    logic [1:0]      mode_cur;
    logic            srch_go = 1'b0;
    logic [ROWS-1:0] srch_key = '0;
    logic [COLS-1:0] match_vec;
    logic            colw_en = 1'b0;
    logic [5:0]      colw_idx = '0;
    logic [ROWS-1:0] colw_data = '0;
    logic            sram_en = 1'b0;
    logic            sram_we = 1'b0;
    logic [5:0]      sram_row = '0;
    logic [COLS-1:0] sram_wdata = '0;
    logic [COLS-1:0] sram_rdata;

    int tests = 0;
    int fails = 0;
    logic [ROWS-1:0] colv [COLS];   // bench model: column contents
    logic [ROWS-1:0] tval [COLS/2]; // ternary values
    logic [ROWS-1:0] tcare [COLS/2];// ternary care masks

    always #2.5 clk = ~clk;

    cfgcam_top uut (.*);

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] row_of(int r);
        logic [63:0] v;
        for (int c = 0; c < COLS; c++) v[c] = colv[c][r];
        return v;
    endfunction

    function automatic logic [63:0] bexp(logic [63:0] key);
        logic [63:0] v;
        for (int c = 0; c < COLS; c++) v[c] = (colv[c] == key);
        return v;
    endfunction

    function automatic logic [63:0] texp(logic [63:0] key);
        logic [63:0] v = '0;
        for (int w = 0; w < COLS/2; w++) v[w] = (((key ^ tval[w]) & tcare[w]) == '0);
        return v;
    endfunction

    task automatic colw(int c, logic [63:0] d, bit model);
        @(negedge clk);
        colw_en = 1'b1; colw_idx = 6'(c); colw_data = d;
        @(negedge clk);
        colw_en = 1'b0;
        if (model) colv[c] = d;
    endtask

    task automatic search(logic [63:0] key);
        @(negedge clk);
        srch_go = 1'b1; srch_key = key;
        @(negedge clk);
        srch_go = 1'b0;
    endtask

    task automatic setmode(logic [1:0] m);
        @(negedge clk);
        mode_sel = m; mode_ld = 1'b1;
        @(negedge clk);
        mode_ld = 1'b0;
    endtask

    task automatic sread(int r);
        @(negedge clk);
        sram_en = 1'b1; sram_we = 1'b0; sram_row = 6'(r);
        @(negedge clk);
        sram_en = 1'b0;
    endtask

    task automatic swrite(int r, logic [63:0] d);
        @(negedge clk);
        sram_en = 1'b1; sram_we = 1'b1; sram_row = 6'(r); sram_wdata = d;
        @(negedge clk);
        sram_en = 1'b0; sram_we = 1'b0;
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    initial begin
        #(5.0 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [63:0] k, held;
        int seed;
        seed = $urandom(32'h5a17);
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 match", match_vec, '0);
        check("R1 rdata", sram_rdata, '0);
        check("R1 mode", 64'(mode_cur), 64'd0);
        rst_n = 1'b1;

        // fill binary words, with a duplicate column
        for (int c = 0; c < COLS; c++) colw(c, rnd64(), 1'b1);
        colw(9, colv[5], 1'b1);
        search(colv[5]);
        check("R2 dup", match_vec, bexp(colv[5]));
        for (int i = 0; i < 10; i++) begin
            k = colv[$urandom_range(COLS-1)];
            search(k);
            check("R2 stored", match_vec, bexp(k));
        end
        search(rnd64());
        check("R2 random", match_vec, bexp(srch_key));
        search('0);
        check("R2 zero", match_vec, bexp('0));

        // R3: single-row mismatch, walking over several rows
        for (int m = 0; m < ROWS; m += 9) begin
            k = colv[3] ^ (64'd1 << m);
            search(k);
            check("R3 walk", {63'd0, match_vec[3]}, 64'd0);
        end

        // R6: key change without strobe leaves result
        search(colv[7]);
        held = match_vec;
        @(negedge clk); srch_key = ~colv[7];
        repeat (2) @(negedge clk);
        check("R6 hold", match_vec, held);

        // R9: mode load while busy is dropped
        @(negedge clk);
        srch_go = 1'b1; srch_key = colv[2]; mode_sel = 2'd2; mode_ld = 1'b1;
        @(negedge clk);
        srch_go = 1'b0; mode_ld = 1'b0;
        check("R9 busy", 64'(mode_cur), 64'd0);
        setmode(2'd3);
        check("R1 code3", 64'(mode_cur), 64'd0);
        setmode(2'd2);
        check("R9 idle", 64'(mode_cur), 64'd2);

        // R10/R9: rows reflect columns after mode switch
        for (int r = 0; r < ROWS; r += 7) begin
            sread(r);
            check("R10 row", sram_rdata, row_of(r));
        end
        // R7: row write then read
        k = rnd64();
        swrite(11, k);
        for (int c = 0; c < COLS; c++) colv[c][11] = k[c];
        sread(11);
        check("R7 rw", sram_rdata, k);
        held = sram_rdata;
        repeat (2) @(negedge clk);
        check("R7 hold", sram_rdata, held);
        // R8: search and column write ignored in SRAM mode
        held = match_vec;
        search(~colv[4]);
        check("R8 srch", match_vec, held);
        colw(0, ~colv[0], 1'b0);
        sread(0);
        check("R8 colw", sram_rdata, row_of(0));

        // back to binary: contents preserved (R9)
        setmode(2'd0);
        search(colv[20]);
        check("R9 keep", match_vec, bexp(colv[20]));

        // R8: SRAM write ignored in CAM mode
        swrite(1, ~row_of(1));
        search(colv[1]);
        check("R8 sram", match_vec, bexp(colv[1]));

        // ternary words
        setmode(2'd1);
        check("R9 tcam", 64'(mode_cur), 64'd1);
        for (int w = 0; w < COLS/2; w++) begin
            tval[w] = rnd64();
            tcare[w] = (w == 0) ? '0 : (w < 4 ? 64'hFFFF_FFFF_FFFF_FFFF : rnd64() | rnd64());
            colw(2*w, tval[w] | ~tcare[w], 1'b1);
            colw(2*w+1, tval[w] & tcare[w], 1'b1);
        end
        tval[6] = tval[5]; tcare[6] = tcare[5];
        colw(12, colv[10], 1'b1);
        colw(13, colv[11], 1'b1);
        for (int i = 0; i < 12; i++) begin
            int w = $urandom_range(COLS/2-1);
            k = (tval[w] & tcare[w]) | (rnd64() & ~tcare[w]);
            if (i == 0) k = (tval[5] & tcare[5]) | ~tcare[5];
            search(k);
            check("R4 tcam", match_vec, texp(k));
            check("R4 upper", 64'(match_vec[63:32]), 64'd0);
        end
        // R5: all-don't-care word matches any key, care-mismatch fails
        search('0);
        check("R5 dc0", {63'd0, match_vec[0]}, 64'd1);
        search('1);
        check("R5 dc1", {63'd0, match_vec[0]}, 64'd1);
        search(~tval[2]);
        check("R5 full", {63'd0, match_vec[2]}, 64'd0);
        k = (tval[9] & tcare[9]) | (~tval[9] & ~tcare[9]);
        search(k);
        check("R5 mixed", match_vec, texp(k));

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule